// File: doc/BRIEF.md
# Three-Slot Freshest-Value Pool

This block is a shared store of three data slots through which a writer publishes values and a reader always collects the newest completed one. Values that are never read are overwritten and not queued. The writer is never blocked by how fast the reader reads, and the reader never waits for new data. Each side waits only briefly for a small two-way arbiter that guards the pointer registers.

Three 2-bit pointers select the slots, and each holds a value from 1 to 3. The `next` pointer names the slot that the coming write will fill. The `last` pointer names the most recently completed write. The `read` pointer names the slot the reader is using.

A write runs in three steps:
1. The data is stored into slot `next` on the edge that accepts the request.
2. The writer takes the arbiter and copies `next` into `last`.
3. The writer picks a new `next` that differs from both `last` and `read`.

A read also runs in steps. The reader takes the arbiter, copies `last` into `read`, and then registers slot `read` onto its output. Both ports share one clock, but their requests arrive with no fixed timing relative to each other.

Top module: `pool3_fresh`

## Requirements
- R1: While reset is asserted and after it is released, `wr_done_o` and `rd_valid_o` are low and `rd_data_o` is 0. The reset pointers are last=1, read=1 and next=2, and every slot holds 0, so a read issued before any write returns 0.
- R2: A write request that is sampled while the writer is idle and the arbiter is free raises `wr_done_o` for exactly one cycle. The pulse begins after the second rising edge that follows the sampling edge.
- R3: A read request that is sampled while the reader is idle and the arbiter is free raises `rd_valid_o` for exactly one cycle. The pulse begins after the third rising edge that follows the sampling edge, and `rd_data_o` carries the value read while `rd_valid_o` is high.
- R4: A read that does not overlap any write returns the data of the most recently completed write.
- R5: A read that overlaps writes returns a value from one of the following: the latest write completed before its request, or a write completed before its `rd_valid_o`. Successive reads never return an older write than an earlier read did.
- R6: Several writes with no read in between overwrite one another, and the next read returns only the last of them.
- R7: A request that arrives while its own side is busy is ignored. It produces no extra `wr_done_o` or `rd_valid_o` pulse, and ignored write data is never returned by a read.
- R8: The next-slot choice is made over (last, read). When the two are equal, next is the cyclic successor of last (1→2, 2→3, 3→1). When they differ, next is the one remaining index. A write never stores into the slot that `read` names, so every read returns a value that was fully written.
- R9: The arbiter grants the pointer registers to one side at a time. It holds the writer's grant across both of the writer's pointer steps. When both sides request together from a free state, it grants the side that was not granted last, starting with the writer after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Single-cycle write request, accepted only while the writer is idle |
| wr_data_i | input | DATA_W | Data stored on the edge that accepts the write |
| wr_done_o | output | 1 | One-cycle pulse after `last` has been updated |
| rd_req_i | input | 1 | Single-cycle read request, accepted only while the reader is idle |
| rd_data_o | output | DATA_W | Most recently read value, held until the next read |
| rd_valid_o | output | 1 | One-cycle pulse when `rd_data_o` is updated |

## Verification
Counted from the edge that samples the request, an uncontended `wr_done_o` becomes visible after two further edges and `rd_valid_o` after three. Directed cases issue each request on a falling edge and count falling edges until the pulse, so each count is an exact expected value. When both sides request together, the counts become 3 and 7 if the writer wins the arbiter, and 5 and 4 if the reader wins. The random phase cannot predict the winner of each race. It instead records the index of the newest completed write at each read request. When `rd_valid_o` appears, it checks that the returned value lies between that index and the newest completed write, and that it never falls behind the previous read.

// File: rtl/pool3_pkg.sv
package pool3_pkg;
  localparam int unsigned SLOT_CNT = 3;
  localparam int unsigned IDX_W    = 2;

  typedef logic [IDX_W-1:0] slot_idx_t;

  typedef enum logic [1:0] {OWN_NONE, OWN_WR, OWN_RD} owner_e;
  typedef enum logic [1:0] {W_IDLE, W_LOCK, W_NEXT} wr_state_e;
  typedef enum logic [1:0] {R_IDLE, R_LOCK, R_OUT} rd_state_e;
endpackage

// File: rtl/pool_next_sel.sv
module pool_next_sel
  import pool3_pkg::*;
(
  input  slot_idx_t last_i,
  input  slot_idx_t read_i,
  output slot_idx_t next_o
);
  logic [2:0] rest;

  // indices 1..3 sum to 6, so the unused index is 6 - last - read
  assign rest = 3'd6 - {1'b0, last_i} - {1'b0, read_i};

  always_comb begin
    if (last_i == read_i) begin
      next_o = (last_i == 2'd3) ? 2'd1 : last_i + 2'd1;
    end else begin
      next_o = rest[IDX_W-1:0];
    end
  end

  always_comb begin
    if (last_i != 2'd0 && read_i != 2'd0) begin
      a_r8_next_fresh: assert (next_o != last_i && next_o != read_i && next_o != 2'd0);
    end
  end
endmodule

// File: rtl/pool_arbiter.sv
module pool_arbiter
  import pool3_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_w_i,
  input  logic req_r_i,
  output logic gnt_w_o,
  output logic gnt_r_o
);
  owner_e owner_q, owner_d;
  logic   last_rd_q, last_rd_d;
  logic   free;

  assign free = (owner_q == OWN_NONE) ||
                (owner_q == OWN_WR && !req_w_i) ||
                (owner_q == OWN_RD && !req_r_i);

  always_comb begin
    owner_d   = owner_q;
    last_rd_d = last_rd_q;
    if (free) begin
      if (req_w_i && req_r_i) begin
        owner_d   = last_rd_q ? OWN_WR : OWN_RD;
        last_rd_d = !last_rd_q;
      end else if (req_w_i) begin
        owner_d   = OWN_WR;
        last_rd_d = 1'b0;
      end else if (req_r_i) begin
        owner_d   = OWN_RD;
        last_rd_d = 1'b1;
      end else begin
        owner_d   = OWN_NONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q   <= OWN_NONE;
      last_rd_q <= 1'b1;
    end else begin
      owner_q   <= owner_d;
      last_rd_q <= last_rd_d;
    end
  end

  assign gnt_w_o = (owner_q == OWN_WR);
  assign gnt_r_o = (owner_q == OWN_RD);

  a_r9_hold_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_w_o && req_w_i) |=> gnt_w_o);

  a_r9_hold_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_r_o && req_r_i) |=> gnt_r_o);

  a_r9_both_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_w_o && !gnt_r_o && req_w_i && req_r_i) |=> $onehot({gnt_w_o, gnt_r_o}));

  a_r9_no_idle_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_w_i && !req_r_i) |=> !gnt_w_o && !gnt_r_o);
endmodule

// File: rtl/pool_slots.sv
module pool_slots
  import pool3_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM    = SLOT_CNT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  slot_idx_t         widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  slot_idx_t         ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slot_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    localparam slot_idx_t IDX = slot_idx_t'(g + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
      end else if (we_i && widx_i == IDX) begin
        slot_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (ridx_i == slot_idx_t'(i + 1)) rdata_o = slot_q[i];
    end
  end
endmodule

// File: rtl/pool3_fresh.sv
module pool3_fresh
  import pool3_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_done_o,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  wr_state_e         wr_st_q;
  rd_state_e         rd_st_q;
  slot_idx_t         l_q, n_q, r_q, n_new;
  logic              gnt_w, gnt_r, req_w, req_r;
  logic              wr_accept;
  logic [DATA_W-1:0] slot_rdata, rd_data_q;
  logic              rd_valid_q;

  assign wr_accept = wr_req_i && (wr_st_q == W_IDLE);
  assign req_w     = (wr_st_q == W_LOCK) || (wr_st_q == W_NEXT);
  assign req_r     = (rd_st_q == R_LOCK);

  pool_arbiter i_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_w_i (req_w),
    .req_r_i (req_r),
    .gnt_w_o (gnt_w),
    .gnt_r_o (gnt_r)
  );

  pool_next_sel i_next (
    .last_i (l_q),
    .read_i (r_q),
    .next_o (n_new)
  );

  // data lands in slot n on the accepting edge; n is stable while the writer idles
  pool_slots #(.DATA_W(DATA_W)) i_slots (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_accept),
    .widx_i  (n_q),
    .wdata_i (wr_data_i),
    .ridx_i  (r_q),
    .rdata_o (slot_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_st_q <= W_IDLE;
      l_q     <= 2'd1;
      n_q     <= 2'd2;
    end else begin
      unique case (wr_st_q)
        W_IDLE: if (wr_req_i) wr_st_q <= W_LOCK;
        W_LOCK: if (gnt_w) begin
          l_q     <= n_q;
          wr_st_q <= W_NEXT;
        end
        W_NEXT: begin
          n_q     <= n_new;
          wr_st_q <= W_IDLE;
        end
        default: wr_st_q <= W_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_st_q    <= R_IDLE;
      r_q        <= 2'd1;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (rd_st_q)
        R_IDLE: if (rd_req_i) rd_st_q <= R_LOCK;
        R_LOCK: if (gnt_r) begin
          r_q     <= l_q;
          rd_st_q <= R_OUT;
        end
        R_OUT: begin
          rd_data_q  <= slot_rdata;
          rd_valid_q <= 1'b1;
          rd_st_q    <= R_IDLE;
        end
        default: rd_st_q <= R_IDLE;
      endcase
    end
  end

  assign wr_done_o  = (wr_st_q == W_NEXT);
  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;

  a_r8_no_write_to_read_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_accept |-> (n_q != r_q));

  a_r8_next_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st_q == W_NEXT) |=> (n_q != l_q) && (n_q != r_q));

  a_r8_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_q != 2'd0) && (n_q != 2'd0) && (r_q != 2'd0));

  a_r9_last_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_w |=> $stable(l_q));

  a_r9_read_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_r |=> $stable(r_q));

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |=> !wr_done_o);

  a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  a_r3_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |=> $stable(rd_data_o) || rd_valid_o);
endmodule

// File: tb/test_pool3_fresh.sv
`timescale 1ns/1ps
module test_pool3_fresh;
  localparam int DW   = 16;
  localparam int HMAX = 1024;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_req_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          rd_req_i = 1'b0;
  logic          wr_done_o, rd_valid_o;
  logic [DW-1:0] rd_data_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  pool3_fresh #(.DATA_W(DW)) i_pool3_fresh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_req_i   (wr_req_i),
    .wr_data_i  (wr_data_i),
    .wr_done_o  (wr_done_o),
    .rd_req_i   (rd_req_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts falling edges from the issuing falling edge until the pulse
  task automatic cnt_wr(output int c);
    c = 0;
    do begin
      @(negedge clk_i);
      wr_req_i = 1'b0;
      c++;
    end while (!wr_done_o && c < 20);
  endtask

  task automatic cnt_rd(output int c);
    c = 0;
    do begin
      @(negedge clk_i);
      rd_req_i = 1'b0;
      c++;
    end while (!rd_valid_o && c < 20);
  endtask

  task automatic do_write(input logic [DW-1:0] v, output int c);
    wr_req_i  = 1'b1;
    wr_data_i = v;
    cnt_wr(c);
  endtask

  task automatic do_read(output int c);
    rd_req_i = 1'b1;
    cnt_rd(c);
  endtask

  // random phase bookkeeping
  logic [DW-1:0] hist [HMAX];
  int            hist_cnt = 0;
  logic [DW-1:0] pend_wr = '0;
  int            rd_lo = 0;
  int            prev_j = 0;
  bit            mon_en = 1'b0;

  always @(negedge clk_i) begin
    if (mon_en) begin
      if (wr_done_o && hist_cnt < HMAX) begin
        hist[hist_cnt] = pend_wr;
        hist_cnt++;
      end
      if (rd_valid_o) begin
        int j;
        j = -1;
        for (int k = 0; k < hist_cnt; k++) if (hist[k] == rd_data_o) j = k;
        check(j >= 0, "R8 read value was a completed write", int'(rd_data_o), int'(hist[hist_cnt-1]));
        check(j >= rd_lo && j <= hist_cnt - 1 && j >= prev_j,
              "R5 read within freshness window", j, rd_lo);
        if (j > prev_j) prev_j = j;
      end
    end
  end

  initial begin
    int cw, cr, npulse;
    int seed;
    seed = $urandom(32'h0000_5eed);

    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(!wr_done_o, "R1 done low in reset", int'(wr_done_o), 0);
    check(!rd_valid_o, "R1 valid low in reset", int'(rd_valid_o), 0);
    check(rd_data_o == '0, "R1 data zero in reset", int'(rd_data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!wr_done_o && !rd_valid_o, "R1 outputs idle after reset", int'({wr_done_o, rd_valid_o}), 0);

    // R1 + R3: read before any write
    do_read(cr);
    check(cr == 4, "R3 read latency", cr, 4);
    check(rd_data_o == '0, "R1 read before write returns reset value", int'(rd_data_o), 0);
    @(negedge clk_i);
    check(!rd_valid_o, "R3 valid single cycle", int'(rd_valid_o), 0);

    // R2 write latency
    do_write(16'h1111, cw);
    check(cw == 3, "R2 write latency", cw, 3);
    @(negedge clk_i);
    check(!wr_done_o, "R2 done single cycle", int'(wr_done_o), 0);

    // R4 isolated read
    do_read(cr);
    check(rd_data_o == 16'h1111, "R4 isolated read freshest", int'(rd_data_o), 'h1111);
    @(negedge clk_i);

    // R6 overwrite without read
    do_write(16'h2222, cw); @(negedge clk_i);
    do_write(16'h3333, cw); @(negedge clk_i);
    do_write(16'h4444, cw); @(negedge clk_i);
    do_read(cr);
    check(rd_data_o == 16'h4444, "R6 only last write survives", int'(rd_data_o), 'h4444);
    @(negedge clk_i);

    // R7 write request while busy
    wr_req_i = 1'b1; wr_data_i = 16'h5555;
    @(negedge clk_i);
    wr_req_i = 1'b1; wr_data_i = 16'h6666;
    npulse = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      wr_req_i = 1'b0;
      if (wr_done_o) npulse++;
    end
    check(npulse == 1, "R7 busy write request ignored", npulse, 1);
    do_read(cr);
    check(rd_data_o == 16'h5555, "R7 ignored write data not stored", int'(rd_data_o), 'h5555);
    @(negedge clk_i);

    // R7 read request while busy
    rd_req_i = 1'b1;
    @(negedge clk_i);
    rd_req_i = 1'b1;
    npulse = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      rd_req_i = 1'b0;
      if (rd_valid_o) npulse++;
    end
    check(npulse == 1, "R7 busy read request ignored", npulse, 1);

    // R9 simultaneous, reader granted last so writer wins
    wr_req_i = 1'b1; wr_data_i = 16'h7777; rd_req_i = 1'b1;
    fork
      cnt_wr(cw);
      cnt_rd(cr);
    join
    check(cw == 3, "R9 writer-first write latency", cw, 3);
    check(cr == 7, "R9 writer-first read latency", cr, 7);
    check(rd_data_o == 16'h7777, "R9 writer-first read sees new value", int'(rd_data_o), 'h7777);
    @(negedge clk_i);

    // lone write makes writer the last grantee
    do_write(16'h8888, cw); @(negedge clk_i);

    // R9 simultaneous, reader wins
    wr_req_i = 1'b1; wr_data_i = 16'h9999; rd_req_i = 1'b1;
    fork
      cnt_wr(cw);
      cnt_rd(cr);
    join
    check(cr == 4, "R9 reader-first read latency", cr, 4);
    check(cw == 5, "R9 reader-first write latency", cw, 5);
    check(rd_data_o == 16'h8888, "R9 reader-first read sees prior value", int'(rd_data_o), 'h8888);
    @(negedge clk_i);
    do_read(cr);
    check(rd_data_o == 16'h9999, "R4 read after contended write", int'(rd_data_o), 'h9999);
    @(negedge clk_i);

    // random overlapping traffic, R5 and R8
    hist[0]  = 16'h9999;
    hist_cnt = 1;
    prev_j   = 0;
    mon_en   = 1'b1;
    fork
      begin
        for (int s = 1; s <= 300; s++) begin
          repeat (1 + ($urandom % 4)) @(negedge clk_i);
          pend_wr   = DW'(s);
          wr_data_i = DW'(s);
          wr_req_i  = 1'b1;
          @(negedge clk_i);
          wr_req_i = 1'b0;
          while (!wr_done_o) @(negedge clk_i);
        end
      end
      begin
        for (int s = 0; s < 250; s++) begin
          repeat (1 + ($urandom % 5)) @(negedge clk_i);
          rd_lo    = hist_cnt - 1;
          rd_req_i = 1'b1;
          @(negedge clk_i);
          rd_req_i = 1'b0;
          while (!rd_valid_o) @(negedge clk_i);
        end
      end
    join
    @(negedge clk_i);
    mon_en = 1'b0;

    // final quiet read returns the last random write
    do_read(cr);
    check(rd_data_o == DW'(300), "R4 final read freshest", int'(rd_data_o), 300);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule